// File: doc/BRIEF.md
# Chainable Multi-Channel Periodic Timer

A bank of down-counting timer channels (four by default) behind a plain register write/read port. Each channel holds a programmed load value. A start copies that value into its counter, and the counter then decrements on every clock. When the counter is already at zero and another decrement is due, the channel expires. On expiry it emits a one-clock pre-trigger, a trigger exactly one clock later, and sets a sticky interrupt flag. After expiry the channel either reloads and keeps running (periodic) or halts (one-shot).

Software can start, stop or restart a channel through a command register. A channel can also be started by a trigger line, chosen per channel from the external trigger inputs or from the trigger outputs of the channels in the bank. Any channel above channel 0 can be chained to the channel below it. A chained channel decrements only when its lower neighbour expires, so the two channels act as one wider counter. The block drives a single interrupt line: the OR of the flags, each gated by its own mask bit. All pins are control or status lines, so no valid/ready handshake applies.

Top module: `pit_bank`

## Requirements
- R1: An unchained running channel decrements its counter by one on each clock. The counter value reads back at channel address 4*i+2. A start loads the counter with the load value, which is written at 4*i+0.
- R2: With load value N and periodic mode, `pre_trig[i]` is high for one clock every N+1 clocks, and the counter reloads to N in the same cycle. The first pulse comes N+1 clocks after the start takes effect. With N=0 the pulse is high on every clock.
- R3: `trig[i]` is high exactly one clock after each cycle in which `pre_trig[i]` is high, and at no other time.
- R4: In one-shot mode (CTRL bit 1 = 0), expiry clears the running bit (CTRL bit 0, read-only). The counter then stays at zero and no further pulses occur until a new start.
- R5: When CTRL bit 3 is 1, a high level on the selected trigger starts the channel on the next clock, loading the counter and setting the running bit. CTRL bit 4 chooses internal (1, another channel's `trig`) or external (0, `ext_trig`). CTRL bits [5+:log2(NCH)] give the line index. Other lines, and any line while bit 3 is 0, have no effect.
- R6: Writing to the command address 4*i+3 acts on the channel. Bit 0 starts it (load and run). Bit 1 stops it, holding the counter. Bit 2 restarts it, reloading the counter on the next clock without setting the flag. Start has priority over stop, and stop has priority over restart.
- R7: With CTRL bit 2 set on channel i>0, channel i decrements only in cycles where channel i-1 expires. Loads A and B in periodic mode therefore give a pre-trigger on channel i every (A+1)*(B+1) clocks.
- R8: The flag of channel i (bit i at address 4*NCH) is set in the same cycle as its pre-trigger and stays set until 1 is written to that bit. Writing 0 to a bit leaves that flag unchanged.
- R9: `irq` is high exactly when some flag bit and the matching mask bit (address 4*NCH+1) are both set.
- R10: After reset every counter, load value, control field, flag, mask and output is zero. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | W | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | W | Register read data (combinational) |
| ext_trig | input | NCH | External trigger lines, level-sensitive |
| pre_trig | output | NCH | Per-channel expiry pre-trigger pulse |
| trig | output | NCH | Per-channel trigger pulse, pre-trigger delayed by one clock |
| irq | output | 1 | Masked OR of the interrupt flags |

## Verification
A wrong counter state shows up as a COUNT readback that drifts from the expected value within one clock. The pre-trigger then moves by the same number of clocks in every later period. A corrupted run bit or mode bit appears as a missing or extra pre-trigger at the next expected expiry. A broken chain link changes the chained channel's period from (A+1)*(B+1) at its first expiry. A broken flag path shows at `irq` and at the flag register in the same cycle as the pre-trigger, and a broken trigger delay shows one clock after it.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int OFS_LOAD  = 0;
  localparam int OFS_CTRL  = 1;
  localparam int OFS_COUNT = 2;
  localparam int OFS_CMD   = 3;

  localparam int CMD_START   = 0;
  localparam int CMD_STOP    = 1;
  localparam int CMD_RESTART = 2;

  localparam int CTL_RUN      = 0;
  localparam int CTL_PERIODIC = 1;
  localparam int CTL_CHAIN    = 2;
  localparam int CTL_TRG_EN   = 3;
  localparam int CTL_TRG_INT  = 4;
  localparam int CTL_SEL      = 5;

  typedef struct packed {
    logic trg_int;
    logic trg_en;
    logic chain;
    logic periodic;
  } chan_mode_t;
endpackage

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int W        = 32,
  parameter int NCH      = 4,
  parameter bit HAS_PREV = 1'b1,
  localparam int SW      = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_we,
  input  logic           ctrl_we,
  input  logic           cmd_we,
  input  logic [W-1:0]   wdata,
  input  logic           prev_expire,
  input  logic [NCH-1:0] ext_trig,
  input  logic [NCH-1:0] int_trig,
  output logic           expire,
  output logic           pre_trig,
  output logic           trig,
  output logic [W-1:0]   load_o,
  output logic [W-1:0]   ctrl_o,
  output logic [W-1:0]   count_o
);
  logic [W-1:0]  load_q, cnt_q;
  logic          run_q, pre_q, trig_q;
  chan_mode_t    mode_q;
  logic [SW-1:0] sel_q;

  logic start_cmd, stop_cmd, restart_cmd, trg_line, trg_start, tick;

  assign start_cmd   = cmd_we & wdata[CMD_START];
  assign stop_cmd    = cmd_we & wdata[CMD_STOP];
  assign restart_cmd = cmd_we & wdata[CMD_RESTART];
  assign trg_line    = mode_q.trg_int ? int_trig[sel_q] : ext_trig[sel_q];
  assign trg_start   = mode_q.trg_en & trg_line;
  assign tick        = (HAS_PREV && mode_q.chain) ? prev_expire : 1'b1;
  assign expire      = run_q & tick & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      pre_q  <= 1'b0;
      trig_q <= 1'b0;
      mode_q <= '0;
      sel_q  <= '0;
    end else begin
      pre_q  <= expire;
      trig_q <= pre_q;
      if (load_we) load_q <= wdata;
      if (ctrl_we) begin
        mode_q <= wdata[CTL_TRG_INT:CTL_PERIODIC];
        sel_q  <= wdata[CTL_SEL +: SW];
      end
      if (start_cmd || trg_start) begin
        run_q <= 1'b1;
        cnt_q <= load_q;
      end else if (stop_cmd) begin
        run_q <= 1'b0;
      end else if (restart_cmd) begin
        cnt_q <= load_q;
      end else if (expire) begin
        if (mode_q.periodic) cnt_q <= load_q;
        else                 run_q <= 1'b0;
      end else if (run_q && tick) begin
        cnt_q <= cnt_q - W'(1);
      end
    end
  end

  assign pre_trig = pre_q;
  assign trig     = trig_q;
  assign load_o   = load_q;
  assign count_o  = cnt_q;
  assign ctrl_o   = W'({sel_q, mode_q, run_q});

  // R1: a running, ticking, nonzero counter with no command goes down by one
  assert_decrement_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && tick && (cnt_q != '0) && !cmd_we && !trg_start
    |=> cnt_q == $past(cnt_q) - W'(1));

  // R3: trigger follows pre-trigger by one clock
  assert_trig_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q |=> trig_q);

  // R4: one-shot expiry halts the channel
  assert_oneshot_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !mode_q.periodic && !start_cmd && !trg_start |=> !run_q);

  // R6: restart reloads the counter
  assert_restart_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_cmd && !start_cmd && !stop_cmd && !trg_start
    |=> cnt_q == $past(load_q));

  // R7: a chained channel holds its count until its neighbour expires
  assert_chain_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cmd_we && !trg_start |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/pit_irq.sv
module pit_irq #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] expire,
  input  logic           clr_we,
  input  logic           mask_we,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] flags,
  output logic [NCH-1:0] mask,
  output logic           irq
);
  logic [NCH-1:0] clr_bits;
  assign clr_bits = clr_we ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= (flags & ~clr_bits) | expire;
      if (mask_we) mask <= wbits;
    end
  end

  assign irq = |(flags & mask);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |=> flags[i]);
    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flags[i] && !(clr_we && wbits[i]) |=> flags[i]);
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we && wbits[i] && !expire[i] |=> !flags[i]);
  end
endmodule

// File: rtl/pit_bank.sv
module pit_bank
  import pit_pkg::*;
#(
  parameter int NCH = 4,
  parameter int W   = 32,
  localparam int AW = $clog2(4 * NCH + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [W-1:0]   rd_data,
  input  logic [NCH-1:0] ext_trig,
  output logic [NCH-1:0] pre_trig,
  output logic [NCH-1:0] trig,
  output logic           irq
);
  localparam int FLAG_ADDR = 4 * NCH;
  localparam int MASK_ADDR = 4 * NCH + 1;

  logic [NCH-1:0] expire, prev_exp, flags, mask;
  logic [W-1:0]   load_v [NCH];
  logic [W-1:0]   ctrl_v [NCH];
  logic [W-1:0]   cnt_v  [NCH];

  assign prev_exp = {expire[NCH-2:0], 1'b0};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pit_channel #(.W(W), .NCH(NCH), .HAS_PREV(i > 0)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_we     (wr_en && (wr_addr == AW'(4 * i + OFS_LOAD))),
      .ctrl_we     (wr_en && (wr_addr == AW'(4 * i + OFS_CTRL))),
      .cmd_we      (wr_en && (wr_addr == AW'(4 * i + OFS_CMD))),
      .wdata       (wr_data),
      .prev_expire (prev_exp[i]),
      .ext_trig    (ext_trig),
      .int_trig    (trig),
      .expire      (expire[i]),
      .pre_trig    (pre_trig[i]),
      .trig        (trig[i]),
      .load_o      (load_v[i]),
      .ctrl_o      (ctrl_v[i]),
      .count_o     (cnt_v[i])
    );
  end

  pit_irq #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .clr_we  (wr_en && (wr_addr == AW'(FLAG_ADDR))),
    .mask_we (wr_en && (wr_addr == AW'(MASK_ADDR))),
    .wbits   (wr_data[NCH-1:0]),
    .flags   (flags),
    .mask    (mask),
    .irq     (irq)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == AW'(4 * i + OFS_LOAD))  rd_data = load_v[i];
      if (rd_addr == AW'(4 * i + OFS_CTRL))  rd_data = ctrl_v[i];
      if (rd_addr == AW'(4 * i + OFS_COUNT)) rd_data = cnt_v[i];
    end
    if (rd_addr == AW'(FLAG_ADDR)) rd_data = W'(flags);
    if (rd_addr == AW'(MASK_ADDR)) rd_data = W'(mask);
  end

  // R9: interrupt line follows masked flags one clock after a new expiry
  assert_irq_on_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    |(expire & mask) && !(wr_en && (wr_addr == AW'(MASK_ADDR))) |=> irq);
endmodule

// File: tb/pit_bank_bench.sv
`timescale 1ns/1ps
module pit_bank_bench;
  localparam int NCH = 4;
  localparam int W   = 32;
  localparam int AW  = $clog2(4 * NCH + 2);
  localparam int A_FLAG = 16;
  localparam int A_MASK = 17;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [W-1:0]   wr_data = '0;
  logic [AW-1:0]  rd_addr = '0;
  logic [W-1:0]   rd_data;
  logic [NCH-1:0] ext_trig = '0;
  logic [NCH-1:0] pre_trig, trig;
  logic           irq;

  int  nchk = 0;
  int  nerr = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  pit_bank #(.NCH(NCH), .W(W)) u_pit_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ext_trig(ext_trig), .pre_trig(pre_trig), .trig(trig), .irq(irq)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] v);
    rd_addr = AW'(a);
    #0.5;
    v = rd_data;
  endtask

  task automatic pulse_ext(input logic [NCH-1:0] p);
    ext_trig = p;
    @(negedge clk);
    ext_trig = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v, c1;
    int pa[4];
    int pb[4];
    pa = '{1, 2, 3, 0};
    pb = '{1, 3, 2, 2};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 pre_trig after reset", pre_trig, 0);
    chk("R10 trig after reset", trig, 0);
    chk("R10 irq after reset", irq, 0);
    rd(2, v);  chk("R10 count0 after reset", v, 0);
    rd(1, v);  chk("R10 ctrl0 after reset", v, 0);
    rd(A_FLAG, v); chk("R10 flags after reset", v, 0);
    rd(18, v); chk("R10 unmapped reads zero", v, 0);

    // R1 R2 R3: periodic sweep on channel 0
    for (int n = 0; n <= 6; n++) begin
      wr(1, 32'h2);
      wr(0, n);
      wr(3, 32'h1);
      for (int k = 0; k <= 3 * (n + 1) + 1; k++) begin
        rd(2, v);
        chk("R1 count0", v, n - (k % (n + 1)));
        chk("R2 pre_trig0", pre_trig[0], (k > 0 && k % (n + 1) == 0) ? 1 : 0);
        chk("R3 trig0", trig[0], (k > 1 && (k - 1) % (n + 1) == 0) ? 1 : 0);
        if (k == n + 1) chk("R9 masked flag keeps irq low", irq, 0);
        @(negedge clk);
      end
      wr(3, 32'h2);
      repeat (3) @(negedge clk);
      wr(A_FLAG, '1);
    end

    // R4: one-shot on channel 1
    wr(5, 32'h0);
    wr(4, 3);
    wr(7, 32'h1);
    for (int k = 0; k <= 10; k++) begin
      rd(6, v);
      chk("R4 one-shot count1", v, (k <= 3) ? 3 - k : 0);
      chk("R4 one-shot pre_trig1", pre_trig[1], (k == 4) ? 1 : 0);
      chk("R3 one-shot trig1", trig[1], (k == 5) ? 1 : 0);
      if (k >= 4) begin
        rd(5, v);
        chk("R4 run bit cleared", v[0], 0);
      end
      @(negedge clk);
    end
    rd(A_FLAG, v); chk("R8 flag1 set", v, 2);
    wr(A_FLAG, 32'h1);
    rd(A_FLAG, v); chk("R8 writing other bit keeps flag1", v, 2);
    wr(A_FLAG, 32'h2);
    rd(A_FLAG, v); chk("R8 write-one clears flag1", v, 0);
    wr(7, 32'h1);
    rd(6, v); chk("R4 new start reloads count1", v, 3);
    rd(5, v); chk("R4 new start sets run bit", v[0], 1);
    repeat (6) @(negedge clk);
    wr(A_FLAG, '1);

    // R6: restart and stop on channel 2
    wr(9, 32'h2);
    wr(8, 10);
    wr(11, 32'h1);
    repeat (4) @(negedge clk);
    rd(10, v); chk("R1 count2 after four clocks", v, 6);
    wr(11, 32'h4);
    rd(10, v); chk("R6 restart reloads count2", v, 10);
    rd(A_FLAG, v); chk("R6 restart sets no flag", v, 0);
    @(negedge clk);
    rd(10, v); chk("R6 counting resumes after restart", v, 9);
    wr(11, 32'h2);
    rd(10, c1); chk("R6 stop holds count2", c1, 9);
    repeat (3) @(negedge clk);
    rd(10, v); chk("R6 count2 frozen while stopped", v, c1);
    rd(9, v);  chk("R6 stop clears run bit", v[0], 0);

    // R5: external trigger start on channel 3
    wr(12, 2);
    wr(13, 32'h2 << 5);
    pulse_ext(4'b0100);
    rd(13, v); chk("R5 trigger ignored while disabled", v[0], 0);
    wr(13, 32'h8 | (32'h2 << 5));
    pulse_ext(4'b0010);
    rd(13, v); chk("R5 unselected line ignored", v[0], 0);
    pulse_ext(4'b0100);
    rd(13, v);  chk("R5 external trigger sets run", v[0], 1);
    rd(14, v);  chk("R5 external trigger loads count3", v, 2);
    repeat (5) @(negedge clk);
    wr(A_FLAG, '1);

    // R5: internal trigger from channel 0
    wr(13, 32'h8 | 32'h10);
    wr(1, 32'h2);
    wr(0, 4);
    wr(3, 32'h1);
    for (int k = 0; k <= 10; k++) begin
      if (k == 6) begin
        rd(13, v); chk("R5 channel3 idle before internal trigger", v[0], 0);
        chk("R3 trig0 at k=6", trig[0], 1);
      end
      if (k == 7) begin
        rd(14, v); chk("R5 internal trigger loads count3", v, 2);
        rd(13, v); chk("R5 internal trigger sets run", v[0], 1);
      end
      chk("R5 pre_trig3 after internal start", pre_trig[3], (k == 10) ? 1 : 0);
      @(negedge clk);
    end
    wr(3, 32'h2);
    wr(13, 32'h0);
    wr(15, 32'h2);
    repeat (4) @(negedge clk);
    wr(A_FLAG, '1);

    // R7: chained pairs, channel 1 counting channel 0 expiries
    for (int t = 0; t < 4; t++) begin
      int p;
      p = (pa[t] + 1) * (pb[t] + 1);
      wr(1, 32'h2);
      wr(0, pa[t]);
      wr(5, 32'h6);
      wr(4, pb[t]);
      wr(7, 32'h1);
      wr(3, 32'h1);
      for (int k = 0; k <= 2 * p; k++) begin
        chk("R7 chained pre_trig1", pre_trig[1], (k > 0 && k % p == 0) ? 1 : 0);
        if (k == pa[t] + 1) begin
          rd(6, v); chk("R7 chained decrement on neighbour expiry", v, pb[t] - 1);
        end
        if (k == pa[t]) begin
          rd(6, v); chk("R7 chained count held", v, pb[t]);
        end
        @(negedge clk);
      end
      wr(3, 32'h2);
      wr(7, 32'h2);
      repeat (3) @(negedge clk);
      wr(A_FLAG, '1);
    end

    // R9: mask gating of irq
    rd(A_FLAG, v); chk("R8 flags cleared", v, 0);
    wr(A_MASK, 32'h2);
    rd(A_MASK, v); chk("R10 mask readback", v, 2);
    wr(5, 32'h0);
    wr(4, 1);
    wr(7, 32'h1);
    chk("R9 irq low before expiry", irq, 0);
    @(negedge clk);
    chk("R9 irq low one clock before expiry", irq, 0);
    @(negedge clk);
    chk("R9 irq high on masked-in expiry", irq, 1);
    wr(A_FLAG, 32'h1);
    chk("R9 irq kept by unrelated clear", irq, 1);
    wr(A_MASK, 32'h0);
    chk("R9 irq low when masked", irq, 0);
    wr(A_MASK, 32'h2);
    chk("R9 irq back when unmasked", irq, 1);
    wr(A_FLAG, 32'h2);
    chk("R9 irq low after clear", irq, 0);
    rd(A_FLAG, v); chk("R8 flags zero after clear", v, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule